// File: doc/BRIEF.md
# Shift-Register-Counted Display Timing Generator

This block produces the line and frame timing for a raster display: a horizontal sync pulse, a vertical sync pulse and a display-enable window. Both position counters are 16-bit linear feedback shift registers, not binary counters. This keeps each counter at one XOR level plus a shift, whatever the line or frame length. Every programmed compare value is therefore the shift-register state reached after N steps from the seed, not the number N. Software works out those states offline and places them on the compare inputs.

A commit strobe starts timing from the seed with the current compare values. A three-bit sync-control code picks one of three behaviours: normal output, blanked output with the counters still running, or power-down. Power-down parks both counters at the seed, and they stay there until the next commit. After reset the block is idle until its first commit.

Top module: `lfsr_vtg`

## Requirements
- R1: Each counter is seeded with 0xFFFF and steps as next = {state[14:0], state[15]^state[4]^state[2]^state[1]}. The horizontal counter takes one step per clock. The first hsync rise after a commit therefore comes as many clocks after the restart as the number of steps encoded in the hsync-start value.
- R2: In the clock after the horizontal counter equals the line-end value, it reloads the seed. A line whose line-end value encodes N steps lasts N+1 clocks.
- R3: The vertical counter takes one step only on the clock that ends a line. It reloads the seed instead when it equals the frame-end value on that clock, so a frame lasts (vertical N+1) lines.
- R4: hsync is high on every clock whose horizontal state lies in the step range from the hsync-start state up to, but not including, the hsync-end state.
- R5: vsync is high for every line whose vertical state lies in the step range from the vsync-start state up to, but not including, the vsync-end state.
- R6: de is high exactly when the horizontal and the vertical states both lie in their display windows, each window running from its start state up to, but not including, its end state.
- R7: Sync-control code 0 drives hsync, vsync and de according to R4, R5 and R6.
- R8: Code 1, and any code other than 0 and 7, forces hsync, vsync and de low while both counters keep running. Returning to code 0 resumes at the position the counters have reached.
- R9: Code 7 reloads both counters to the seed, holds them there and keeps every output low. Leaving code 7 does not restart the counters; only a commit sampled while the code is not 7 does.
- R10: A commit restarts both counters from the seed at once, in the middle of a line or a frame, using the compare values present at that clock.
- R11: The active-low asynchronous reset puts both counters at the seed in the halted state, with all outputs low until the first commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit | input | 1 | One-clock strobe: restart timing from the seed |
| syncMode | input | 3 | 0 normal, 7 power-down, other codes blank |
| hLineEnd | input | 16 | Shift-register state of the last clock of a line |
| hDispStart | input | 16 | State at which the horizontal display window opens |
| hDispEnd | input | 16 | State at which the horizontal display window closes |
| hSyncStart | input | 16 | State at which hsync rises |
| hSyncEnd | input | 16 | State at which hsync falls |
| vFrameEnd | input | 16 | State of the last line of a frame |
| vDispStart | input | 16 | State at which the vertical display window opens |
| vDispEnd | input | 16 | State at which the vertical display window closes |
| vSyncStart | input | 16 | State at which vsync rises |
| vSyncEnd | input | 16 | State at which vsync falls |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Display enable |

## Verification
A horizontal counter that takes a wrong step or misses its line-end match shows up within one line. The hsync edges then move or stop recurring every line, and the vertical count drifts from there. A window flag that is set or cleared on the wrong state shows as an hsync, vsync or de pulse that is one position too long or too short. That error is visible in the first line or frame after a commit. Faults in the halted state show up as outputs toggling in power-down, or as timing that resumes without a commit, on the first clock after the mode change.

// File: rtl/lfsr_vtg_pkg.sv
package lfsr_vtg_pkg;
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] SEED = '1;
  localparam int NUM_AXES = 2;
  localparam int AX_H = 0;
  localparam int AX_V = 1;
  localparam int TAP_A = CNT_W - 1;
  localparam int TAP_B = 4;
  localparam int TAP_C = 2;
  localparam int TAP_D = 1;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN   = 3'd0,
    MODE_BLANK = 3'd1,
    MODE_OFF   = 3'd7
  } syncMode_e;

  typedef struct packed {
    logic load;
    logic run;
    logic show;
  } ctrlStrb_t;

  typedef struct packed {
    logic [CNT_W-1:0] endCnt;
    logic [CNT_W-1:0] dispStart;
    logic [CNT_W-1:0] dispEnd;
    logic [CNT_W-1:0] syncStart;
    logic [CNT_W-1:0] syncEnd;
  } axisCfg_t;

  function automatic logic [CNT_W-1:0] lfsrStep(input logic [CNT_W-1:0] s);
    return {s[CNT_W-2:0], s[TAP_A] ^ s[TAP_B] ^ s[TAP_C] ^ s[TAP_D]};
  endfunction
endpackage

// File: rtl/lfsr_vtg_ctrl.sv
module lfsr_vtg_ctrl
  import lfsr_vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [MODE_W-1:0] syncMode,
  output ctrlStrb_t         strb
);
  logic halted;
  logic modeOff;
  logic modeRun;

  assign modeOff = (syncMode == MODE_OFF);
  assign modeRun = (syncMode == MODE_RUN);

  // Halted from reset and power-down; only a commit outside power-down releases it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b1;
    end else if (modeOff) begin
      halted <= 1'b1;
    end else if (commit) begin
      halted <= 1'b0;
    end
  end

  always_comb begin
    strb.load = commit | modeOff;
    strb.run  = ~halted;
    strb.show = ~halted & modeRun;
  end
endmodule

// File: rtl/lfsr_vtg_axis.sv
module lfsr_vtg_axis
  import lfsr_vtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  axisCfg_t         cfg,
  output logic [CNT_W-1:0] cnt,
  output logic             atEnd,
  output logic             inSync,
  output logic             inDisp
);
  logic [CNT_W-1:0] nxt;

  assign atEnd = (cnt == cfg.endCnt);
  assign nxt   = atEnd ? SEED : lfsrStep(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= SEED;
      inSync <= 1'b0;
      inDisp <= 1'b0;
    end else if (load) begin
      cnt    <= SEED;
      inSync <= (SEED == cfg.syncStart);
      inDisp <= (SEED == cfg.dispStart);
    end else if (adv) begin
      cnt <= nxt;
      // Flags follow the state being entered, so they line up with the counter.
      if (nxt == cfg.syncStart)    inSync <= 1'b1;
      else if (nxt == cfg.syncEnd) inSync <= 1'b0;
      if (nxt == cfg.dispStart)    inDisp <= 1'b1;
      else if (nxt == cfg.dispEnd) inDisp <= 1'b0;
    end
  end
endmodule

// File: rtl/lfsr_vtg_dp.sv
module lfsr_vtg_dp
  import lfsr_vtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrb_t        strb,
  input  axisCfg_t         cfg [NUM_AXES],
  output logic [CNT_W-1:0] hCnt,
  output logic [CNT_W-1:0] vCnt,
  output logic             hsync,
  output logic             vsync,
  output logic             de
);
  logic [CNT_W-1:0] cnt    [NUM_AXES];
  logic [NUM_AXES-1:0] atEnd;
  logic [NUM_AXES-1:0] adv;
  logic [NUM_AXES-1:0] inSync;
  logic [NUM_AXES-1:0] inDisp;

  // Each axis advances when every faster axis is at its end state.
  always_comb begin
    adv[AX_H] = strb.run;
    for (int i = 1; i < NUM_AXES; i++) begin
      adv[i] = adv[i-1] & atEnd[i-1];
    end
  end

  for (genvar gi = 0; gi < NUM_AXES; gi++) begin : gAxis
    lfsr_vtg_axis u_axis (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (strb.load),
      .adv    (adv[gi]),
      .cfg    (cfg[gi]),
      .cnt    (cnt[gi]),
      .atEnd  (atEnd[gi]),
      .inSync (inSync[gi]),
      .inDisp (inDisp[gi])
    );
  end

  assign hCnt  = cnt[AX_H];
  assign vCnt  = cnt[AX_V];
  assign hsync = strb.show & inSync[AX_H];
  assign vsync = strb.show & inSync[AX_V];
  assign de    = strb.show & (&inDisp);
endmodule

// File: rtl/lfsr_vtg.sv
module lfsr_vtg
  import lfsr_vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [MODE_W-1:0] syncMode,
  input  logic [CNT_W-1:0]  hLineEnd,
  input  logic [CNT_W-1:0]  hDispStart,
  input  logic [CNT_W-1:0]  hDispEnd,
  input  logic [CNT_W-1:0]  hSyncStart,
  input  logic [CNT_W-1:0]  hSyncEnd,
  input  logic [CNT_W-1:0]  vFrameEnd,
  input  logic [CNT_W-1:0]  vDispStart,
  input  logic [CNT_W-1:0]  vDispEnd,
  input  logic [CNT_W-1:0]  vSyncStart,
  input  logic [CNT_W-1:0]  vSyncEnd,
  output logic              hsync,
  output logic              vsync,
  output logic              de
);
  ctrlStrb_t        strb;
  axisCfg_t         cfg [NUM_AXES];
  logic [CNT_W-1:0] hCnt;
  logic [CNT_W-1:0] vCnt;

  assign cfg[AX_H] = '{endCnt: hLineEnd, dispStart: hDispStart, dispEnd: hDispEnd,
                       syncStart: hSyncStart, syncEnd: hSyncEnd};
  assign cfg[AX_V] = '{endCnt: vFrameEnd, dispStart: vDispStart, dispEnd: vDispEnd,
                       syncStart: vSyncStart, syncEnd: vSyncEnd};

  lfsr_vtg_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .syncMode (syncMode),
    .strb     (strb)
  );

  lfsr_vtg_dp u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strb  (strb),
    .cfg   (cfg),
    .hCnt  (hCnt),
    .vCnt  (vCnt),
    .hsync (hsync),
    .vsync (vsync),
    .de    (de)
  );
endmodule

// File: rtl/lfsr_vtg_chk.sv
module lfsr_vtg_chk
  import lfsr_vtg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic [MODE_W-1:0] syncMode,
  input logic [CNT_W-1:0]  hLineEnd,
  input ctrlStrb_t         strb,
  input logic [CNT_W-1:0]  hCnt,
  input logic [CNT_W-1:0]  vCnt,
  input logic              hsync,
  input logic              vsync,
  input logic              de
);
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.run && !strb.load && hCnt != hLineEnd) |=>
      (hCnt == {$past(hCnt[14:0]), $past(hCnt[15] ^ hCnt[4] ^ hCnt[2] ^ hCnt[1])}));

  p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.run && !strb.load && hCnt == hLineEnd) |=> (hCnt == SEED));

  p_vert_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.run && !strb.load && hCnt != hLineEnd) |=> $stable(vCnt));

  p_de_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (syncMode == 3'd0));

  p_blank_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (syncMode != 3'd0) |-> (!hsync && !vsync && !de));

  p_off_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (syncMode == 3'd7) |=> (hCnt == SEED && vCnt == SEED && !strb.run && !hsync && !vsync && !de));

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.run && !strb.load) |=> ($stable(hCnt) && $stable(vCnt)));

  p_commit_seed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (hCnt == SEED && vCnt == SEED));
endmodule

bind lfsr_vtg lfsr_vtg_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .commit   (commit),
  .syncMode (syncMode),
  .hLineEnd (hLineEnd),
  .strb     (strb),
  .hCnt     (hCnt),
  .vCnt     (vCnt),
  .hsync    (hsync),
  .vsync    (vsync),
  .de       (de)
);

// File: tb/lfsr_vtg_tb.sv
module lfsr_vtg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        commit = 1'b0;
  logic [2:0]  syncMode = 3'd0;
  logic [15:0] hLineEnd, hDispStart, hDispEnd, hSyncStart, hSyncEnd;
  logic [15:0] vFrameEnd, vDispStart, vDispEnd, vSyncStart, vSyncEnd;
  logic        hsync, vsync, de;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  // Step counts behind the compare states (the reference works in plain positions).
  int cHEnd, cHdS, cHdE, cHsS, cHsE, cVEnd, cVdS, cVdE, cVsS, cVsE;

  int hPos = 0;
  int vPos = 0;
  bit mHalted = 1'b1;
  bit monOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_vtg u_dut (
    .clk(clk), .rst_n(rst_n), .commit(commit), .syncMode(syncMode),
    .hLineEnd(hLineEnd), .hDispStart(hDispStart), .hDispEnd(hDispEnd),
    .hSyncStart(hSyncStart), .hSyncEnd(hSyncEnd),
    .vFrameEnd(vFrameEnd), .vDispStart(vDispStart), .vDispEnd(vDispEnd),
    .vSyncStart(vSyncStart), .vSyncEnd(vSyncEnd),
    .hsync(hsync), .vsync(vsync), .de(de)
  );

  function automatic logic [15:0] stateAfter(input int n);
    logic [15:0] s = 16'hFFFF;
    for (int i = 0; i < n; i++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  function automatic bit inWin(input int p, input int s, input int e);
    return (p >= s) && (p < e);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkInt(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic applyCfg(input int he, input int hds, input int hde, input int hss, input int hse,
                          input int ve, input int vds, input int vde, input int vss, input int vse);
    cHEnd = he; cHdS = hds; cHdE = hde; cHsS = hss; cHsE = hse;
    cVEnd = ve; cVdS = vds; cVdE = vde; cVsS = vss; cVsE = vse;
    hLineEnd = stateAfter(he);  hDispStart = stateAfter(hds); hDispEnd = stateAfter(hde);
    hSyncStart = stateAfter(hss); hSyncEnd = stateAfter(hse);
    vFrameEnd = stateAfter(ve); vDispStart = stateAfter(vds); vDispEnd = stateAfter(vde);
    vSyncStart = stateAfter(vss); vSyncEnd = stateAfter(vse);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doCommit();
    commit = 1'b1;
    @(posedge clk);
    #1;
    commit = 1'b0;
  endtask

  task automatic clocksToHsRise(output int n);
    n = 0;
    @(negedge clk);
    while (!hsync) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic risePeriod(input bit useV, output int n);
    logic prev;
    logic cur;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      cur = useV ? vsync : hsync;
      if (cur && !prev) break;
      prev = cur;
    end
    n = 0;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      cur = useV ? vsync : hsync;
      if (cur && !prev) break;
      prev = cur;
    end
  endtask

  // Behavioural position reference, stepped on the same edges as the design.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hPos = 0; vPos = 0; mHalted = 1'b1;
    end else if (syncMode == 3'd7) begin
      hPos = 0; vPos = 0; mHalted = 1'b1;
    end else if (commit) begin
      hPos = 0; vPos = 0; mHalted = 1'b0;
    end else if (!mHalted) begin
      if (hPos == cHEnd) begin
        hPos = 0;
        vPos = (vPos == cVEnd) ? 0 : vPos + 1;
      end else begin
        hPos++;
      end
    end
  end

  always @(negedge clk) begin
    if (monOn && !done) begin
      bit show;
      show = !mHalted && (syncMode == 3'd0);
      if (mHalted && syncMode != 3'd7) begin
        check("R9/R11 halted hsync", hsync, 1'b0);
        check("R9/R11 halted vsync", vsync, 1'b0);
        check("R9/R11 halted de", de, 1'b0);
      end else if (syncMode == 3'd7) begin
        check("R9 power-down hsync", hsync, 1'b0);
        check("R9 power-down vsync", vsync, 1'b0);
        check("R9 power-down de", de, 1'b0);
      end else if (!show) begin
        check("R8 blank hsync", hsync, 1'b0);
        check("R8 blank vsync", vsync, 1'b0);
        check("R8 blank de", de, 1'b0);
      end else begin
        check("R4 R7 hsync", hsync, inWin(hPos, cHsS, cHsE));
        check("R5 R7 vsync", vsync, inWin(vPos, cVsS, cVsE));
        check("R6 R7 de", de, inWin(hPos, cHdS, cHdE) && inWin(vPos, cVdS, cVdE));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int n;
    // Configuration A: 20-clock lines, 10-line frames.
    applyCfg(19, 0, 12, 14, 17, 9, 0, 7, 7, 9);
    syncMode = 3'd0;
    cycles(3);
    rst_n = 1'b1;
    monOn = 1'b1;
    @(negedge clk);
    check("R11 reset hsync", hsync, 1'b0);
    check("R11 reset vsync", vsync, 1'b0);
    check("R11 reset de", de, 1'b0);
    @(posedge clk); #1;
    cycles(10);

    doCommit();
    clocksToHsRise(n);
    checkInt("R1 clocks to first hsync rise", n, 14);
    risePeriod(1'b0, n);
    checkInt("R2 line length", n, 20);
    risePeriod(1'b1, n);
    checkInt("R3 frame length", n, 200);
    @(posedge clk); #1;
    cycles(300);

    // R8: blank codes keep the counters running.
    syncMode = 3'd1;
    cycles(37);
    syncMode = 3'd3;
    cycles(10);
    syncMode = 3'd0;
    cycles(250);

    // R9: power-down, release without commit, commit during power-down.
    syncMode = 3'd7;
    cycles(15);
    syncMode = 3'd0;
    cycles(30);
    syncMode = 3'd7;
    commit = 1'b1;
    cycles(1);
    commit = 1'b0;
    syncMode = 3'd0;
    cycles(20);

    // R10: configuration B with 16-clock lines and 8-line frames.
    applyCfg(15, 2, 10, 11, 13, 7, 1, 6, 6, 7);
    doCommit();
    clocksToHsRise(n);
    checkInt("R10 restart to first hsync rise", n, 11);
    @(posedge clk); #1;
    cycles(250);
    cycles(7);
    doCommit();
    clocksToHsRise(n);
    checkInt("R10 mid-frame restart to hsync rise", n, 11);
    risePeriod(1'b0, n);
    checkInt("R2 line length B", n, 16);
    risePeriod(1'b1, n);
    checkInt("R3 frame length B", n, 128);
    @(posedge clk); #1;
    cycles(50);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule